// File: doc/BRIEF.md
# Clock Generator Strap Latch and Power-Down Control

This block is the control core of a multi-output clock generator. At power-up one shared pin reports power-good (active low). On the first reference-clock edge that sees it low, the block captures three frequency-select straps and one 24/48 MHz select strap. Those levels come from pins that later carry clock outputs. Once the straps are held, the block turns those pins into outputs through per-pin output enables. From then on it treats the power-good pin as an active-high power-down request.

A power-down request drops every clock enable at once, without waiting for a clock edge. The enables come back through a two-stage synchroniser. The PCI enables can also be held off by a PCI stop request, but the free-running PCI enables ignore that request.

The block also drives an active-low system reset pulse of fixed length. The pulse fires when a register write changes the latched frequency ratio, or when a one-shot watchdog, armed by a register write, runs out.

Top module: `clkgen_strap_ctrl`

## Requirements
- R1: On the first rising `clk` edge with `straps_valid` low and `pg_pin_n` low, `fs_latched` takes `strap_fs_in` (bit 0 = select A, bit 1 = B, bit 2 = C) and `straps_valid` goes high. Later strap-pin levels and later power-good transitions never change the latched straps.
- R2: `pin_oe` is all zeros until the capture edge and all ones from that edge on. Bits 0..2 drive the frequency-select pins; bit 3 drives the 24/48 select pin.
- R3: `sel24` holds the 24/48 strap captured at the capture edge: 1 selects the 24 MHz output, 0 selects 48 MHz.
- R4: After capture, `pg_pin_n` high forces every bit of `clk_en_main`, `clk_en_pci` and `clk_en_free` low at once, with no clock edge needed.
- R5: After `pg_pin_n` falls again, the enables stay low through the first rising edge and come back after the second.
- R6: While the block runs, `clk_en_pci` is all ones when `pci_stop` is low and all zeros when it is high. `clk_en_free` and `clk_en_main` are all ones whatever `pci_stop` is.
- R7: A `ratio_wr` after capture, with `ratio_wr_data` different from `fs_latched`, updates `fs_latched` and drives `sys_rst_n` low for exactly RST_CYCLES cycles, starting after that edge. A write of the same value, or any write before capture, changes nothing and gives no pulse.
- R8: A `wdt_arm` pulse (re)loads the watchdog. `sys_rst_n` stays high through WDT_CYCLES-1 further edges and drops after the WDT_CYCLES-th. The watchdog then stays idle until it is armed again.
- R9: After a synchronous `rst_n` reset: `straps_valid` is 0, `pin_oe` is 0, every enable is 0 and `sys_rst_n` is 1.
- R10: Before capture, every clock enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| pg_pin_n | input | 1 | Shared pin: power-good (low) before capture, power-down request (high) after |
| strap_fs_in | input | FS_W | Frequency-select strap levels read from the shared pins |
| strap_sel_in | input | 1 | 24/48 select strap level |
| pci_stop | input | 1 | PCI stop request, active high |
| ratio_wr | input | 1 | Frequency-ratio register write strobe |
| ratio_wr_data | input | FS_W | New frequency ratio |
| wdt_arm | input | 1 | Watchdog (re)arm strobe |
| pin_oe | output | FS_W+1 | Output enables of the dual-purpose pins |
| straps_valid | output | 1 | Straps captured |
| fs_latched | output | FS_W | Current frequency ratio |
| sel24 | output | 1 | 1 = 24 MHz, 0 = 48 MHz |
| clk_en_main | output | N_MAIN | Enables of the CPU, SRC, PCI Express and fixed clocks |
| clk_en_pci | output | N_PCI | Enables of the stoppable PCI clocks |
| clk_en_free | output | N_FREE | Enables of the free-running PCI clocks |
| sys_rst_n | output | 1 | System reset pulse, active low |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- Strap capture shows after the one edge that sees power-good.
- A power-down removes the enables with no edge at all. The bench checks this 1 ns after the pin rises, between edges.
- Recovery from power-down is due after the second edge, so the bench checks the enables after one edge (still low) and after two (back on).
- A reset pulse shows after the edge that takes the write or the expiry. The bench counts its length in low samples, taken one per cycle.

Inputs change on falling edges and outputs are sampled on falling edges, so each sample falls between known rising edges.

// File: rtl/clkgen_strap_pkg.sv
// Package: shared parameters of the strap latch / power-down control block.
// Assumes nothing; holds defaults only.
package clkgen_strap_pkg;
    localparam int FS_W_DEF   = 3;   // number of frequency-select straps
    localparam int N_MAIN_DEF = 4;   // non-PCI clock enables
    localparam int N_PCI_DEF  = 6;   // stoppable PCI clock enables
    localparam int N_FREE_DEF = 3;   // free-running PCI clock enables
    localparam int RST_DEF    = 8;   // reset pulse length in clk cycles
    localparam int WDT_DEF    = 100; // watchdog timeout in clk cycles
endpackage

// File: rtl/clkgen_strap_latch.sv
// Strap latch: captures the strap levels on the first edge that sees
// power-good low, then holds them; owns the frequency-ratio register.
// Assumes pg_pin_n and straps are stable around the capture edge
// (board-level power sequencing guarantees this).
module clkgen_strap_latch #(
    parameter int FS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_pin_n,
    input  logic [FS_W-1:0] strap_fs_in,
    input  logic            strap_sel_in,
    input  logic            ratio_wr,
    input  logic [FS_W-1:0] ratio_wr_data,
    output logic            valid,
    output logic [FS_W-1:0] fs_q,
    output logic            sel_q,
    output logic            ratio_change
);
    logic capture;

    // Capture exactly once: not yet valid and power-good asserted.
    assign capture      = !valid && !pg_pin_n;
    // A ratio change is a post-capture write of a different value.
    assign ratio_change = valid && ratio_wr && (ratio_wr_data != fs_q);

    // Hold the captured straps; the ratio field may be rewritten later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            fs_q  <= '0;
            sel_q <= 1'b0;
        end else if (capture) begin
            valid <= 1'b1;
            fs_q  <= strap_fs_in;
            sel_q <= strap_sel_in;
        end else if (ratio_change) begin
            fs_q  <= ratio_wr_data;
        end
    end
endmodule

// File: rtl/clkgen_pd_sync.sv
// Power-down synchroniser: the request sets every stage at once
// (asynchronous assertion); release ripples through SYNC_STAGES edges.
// Assumes pd_req is glitch-free (a pin gated by a register).
module clkgen_pd_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    output logic pd_hold
);
    logic [SYNC_STAGES-1:0] stg;

    // Async set on request, synchronous reset and shift otherwise.
    always_ff @(posedge clk or posedge pd_req) begin
        if (pd_req) begin
            stg <= '1;
        end else if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[SYNC_STAGES-2:0], 1'b0};
        end
    end

    assign pd_hold = stg[SYNC_STAGES-1];
endmodule

// File: rtl/clkgen_rst_pulse.sv
// Reset pulse generator with a one-shot watchdog. A trigger (ratio change
// or watchdog expiry) loads a pulse counter; sys_rst_n is low while it is
// non-zero. Assumes triggers are single-cycle strobes.
module clkgen_rst_pulse #(
    parameter int RST_CYCLES = 8,
    parameter int WDT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ratio_change,
    input  logic wdt_arm,
    output logic sys_rst_n
);
    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam int WW = $clog2(WDT_CYCLES + 1);

    logic [RW-1:0] rst_cnt;
    logic [WW-1:0] wdt_cnt;
    logic          wdt_armed;
    logic          wdt_expire;
    logic          trigger;

    assign wdt_expire = wdt_armed && (wdt_cnt == WW'(1));
    assign trigger    = ratio_change || wdt_expire;

    // Watchdog: reload on arm, count down while armed, disarm on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_cnt   <= '0;
            wdt_armed <= 1'b0;
        end else if (wdt_arm) begin
            wdt_cnt   <= WW'(WDT_CYCLES);
            wdt_armed <= 1'b1;
        end else if (wdt_expire) begin
            wdt_cnt   <= '0;
            wdt_armed <= 1'b0;
        end else if (wdt_armed) begin
            wdt_cnt   <= wdt_cnt - WW'(1);
        end
    end

    // Pulse counter: load on trigger, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cnt <= '0;
        end else if (trigger) begin
            rst_cnt <= RW'(RST_CYCLES);
        end else if (rst_cnt != '0) begin
            rst_cnt <= rst_cnt - RW'(1);
        end
    end

    assign sys_rst_n = (rst_cnt == '0);
endmodule

// File: rtl/clkgen_strap_ctrl.sv
// Top: strap latch, pin direction control, power-down gating of all clock
// enables, PCI stop gating with free-running exemption, reset pulse.
// Assumes clk is the free-running reference clock, present whenever
// rst_n is released.
module clkgen_strap_ctrl #(
    parameter int FS_W        = clkgen_strap_pkg::FS_W_DEF,
    parameter int N_MAIN      = clkgen_strap_pkg::N_MAIN_DEF,
    parameter int N_PCI       = clkgen_strap_pkg::N_PCI_DEF,
    parameter int N_FREE      = clkgen_strap_pkg::N_FREE_DEF,
    parameter int RST_CYCLES  = clkgen_strap_pkg::RST_DEF,
    parameter int WDT_CYCLES  = clkgen_strap_pkg::WDT_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_pin_n,
    input  logic [FS_W-1:0]   strap_fs_in,
    input  logic              strap_sel_in,
    input  logic              pci_stop,
    input  logic              ratio_wr,
    input  logic [FS_W-1:0]   ratio_wr_data,
    input  logic              wdt_arm,
    output logic [FS_W:0]     pin_oe,
    output logic              straps_valid,
    output logic [FS_W-1:0]   fs_latched,
    output logic              sel24,
    output logic [N_MAIN-1:0] clk_en_main,
    output logic [N_PCI-1:0]  clk_en_pci,
    output logic [N_FREE-1:0] clk_en_free,
    output logic              sys_rst_n
);
    logic ratio_change;
    logic pd_req;
    logic pd_hold;
    logic run;

    clkgen_strap_latch #(.FS_W(FS_W)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .pg_pin_n     (pg_pin_n),
        .strap_fs_in  (strap_fs_in),
        .strap_sel_in (strap_sel_in),
        .ratio_wr     (ratio_wr),
        .ratio_wr_data(ratio_wr_data),
        .valid        (straps_valid),
        .fs_q         (fs_latched),
        .sel_q        (sel24),
        .ratio_change (ratio_change)
    );

    // The pin means power-down only once the straps are held.
    assign pd_req = straps_valid && pg_pin_n;

    clkgen_pd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_req (pd_req),
        .pd_hold(pd_hold)
    );

    clkgen_rst_pulse #(.RST_CYCLES(RST_CYCLES), .WDT_CYCLES(WDT_CYCLES)) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_change(ratio_change),
        .wdt_arm     (wdt_arm),
        .sys_rst_n   (sys_rst_n)
    );

    assign run    = straps_valid && !pd_hold;
    assign pin_oe = {(FS_W+1){straps_valid}};

    // Per-output enable fan-out; only the stoppable PCI group sees pci_stop.
    for (genvar i = 0; i < N_MAIN; i++) begin : g_main
        assign clk_en_main[i] = run;
    end
    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        assign clk_en_pci[i] = run && !pci_stop;
    end
    for (genvar i = 0; i < N_FREE; i++) begin : g_free
        assign clk_en_free[i] = run;
    end
endmodule

// File: rtl/clkgen_strap_ctrl_checker.sv
// Checker: temporal properties of clkgen_strap_ctrl, bound to the top.
module clkgen_strap_ctrl_checker #(
    parameter int FS_W   = 3,
    parameter int N_MAIN = 4,
    parameter int N_PCI  = 6,
    parameter int N_FREE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pg_pin_n,
    input logic              ratio_wr,
    input logic [FS_W-1:0]   ratio_wr_data,
    input logic              straps_valid,
    input logic [FS_W-1:0]   fs_latched,
    input logic              sel24,
    input logic [N_MAIN-1:0] clk_en_main,
    input logic [N_PCI-1:0]  clk_en_pci,
    input logic [N_FREE-1:0] clk_en_free,
    input logic              sys_rst_n
);
    // R1: once captured, the straps stay captured
    p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> straps_valid);

    // R3: the 24/48 select never moves after capture
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> $stable(sel24));

    // R4: power-down request holds every enable low
    p_pd_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid && pg_pin_n) |->
        (clk_en_main == '0 && clk_en_pci == '0 && clk_en_free == '0));

    // R10: no enable before capture
    p_no_en_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_valid |-> (clk_en_main == '0 && clk_en_free == '0 && clk_en_pci == '0));

    // R6: free-running enables follow the main enables, not pci_stop
    p_free_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_free == '0) == (clk_en_main == '0));

    // R7: a differing ratio write starts a reset pulse
    p_rst_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid && ratio_wr && ratio_wr_data != fs_latched) |=> !sys_rst_n);
endmodule

bind clkgen_strap_ctrl clkgen_strap_ctrl_checker #(
    .FS_W(FS_W), .N_MAIN(N_MAIN), .N_PCI(N_PCI), .N_FREE(N_FREE)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pg_pin_n     (pg_pin_n),
    .ratio_wr     (ratio_wr),
    .ratio_wr_data(ratio_wr_data),
    .straps_valid (straps_valid),
    .fs_latched   (fs_latched),
    .sel24        (sel24),
    .clk_en_main  (clk_en_main),
    .clk_en_pci   (clk_en_pci),
    .clk_en_free  (clk_en_free),
    .sys_rst_n    (sys_rst_n)
);

// File: tb/clkgen_strap_ctrl_bench.sv
module clkgen_strap_ctrl_bench;
    localparam int FS_W = 3, N_MAIN = 4, N_PCI = 6, N_FREE = 3;
    localparam int RST = 8, WDT = 100;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              pg_pin_n;
    logic [FS_W-1:0]   strap_fs_in;
    logic              strap_sel_in;
    logic              pci_stop;
    logic              ratio_wr;
    logic [FS_W-1:0]   ratio_wr_data;
    logic              wdt_arm;
    logic [FS_W:0]     pin_oe;
    logic              straps_valid;
    logic [FS_W-1:0]   fs_latched;
    logic              sel24;
    logic [N_MAIN-1:0] clk_en_main;
    logic [N_PCI-1:0]  clk_en_pci;
    logic [N_FREE-1:0] clk_en_free;
    logic              sys_rst_n;

    int n_chk = 0, n_fail = 0;
    logic [FS_W-1:0] fs_model;
    int rst_model;
    logic done = 1'b0;

    clkgen_strap_ctrl #(.RST_CYCLES(RST), .WDT_CYCLES(WDT)) u_clkgen_strap_ctrl (.*);

    always #10 clk = ~clk;

    // Expected enables packed as {free, pci, main}.
    function automatic logic [N_FREE+N_PCI+N_MAIN-1:0] exp_en(input logic run, input logic stop);
        return {{N_FREE{run}}, {N_PCI{run && !stop}}, {N_MAIN{run}}};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_en(input string req, input logic run);
        check(req, 32'({clk_en_free, clk_en_pci, clk_en_main}), 32'(exp_en(run, pci_stop)));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; pg_pin_n = 1'b1; strap_fs_in = 3'b101; strap_sel_in = 1'b1;
        pci_stop = 1'b0; ratio_wr = 1'b0; ratio_wr_data = '0; wdt_arm = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R9 reset state
        check("R9 valid", 32'(straps_valid), 0);
        check("R9 oe", 32'(pin_oe), 0);
        check("R9 rst", 32'(sys_rst_n), 1);
        check_en("R10 enables before capture", 1'b0);

        // R7 write before capture ignored
        ratio_wr = 1'b1; ratio_wr_data = 3'b010;
        step(1);
        ratio_wr = 1'b0;
        check("R7 early write no pulse", 32'(sys_rst_n), 1);
        check("R1 not captured yet", 32'(straps_valid), 0);

        // R1/R2/R3 capture
        pg_pin_n = 1'b0;
        step(1);
        check("R1 fs captured", 32'(fs_latched), 32'b101);
        check("R1 valid", 32'(straps_valid), 1);
        check("R2 oe on", 32'(pin_oe), 32'hF);
        check("R3 sel24 = 1 (24MHz)", 32'(sel24), 1);
        check_en("R6 running", 1'b1);

        // R1 later strap changes and power cycles ignored
        strap_fs_in = 3'b010; strap_sel_in = 1'b0;
        pg_pin_n = 1'b1; #1;
        check_en("R4 async power-down", 1'b0);
        step(1);
        check_en("R4 held", 1'b0);
        pg_pin_n = 1'b0;
        step(1);
        check_en("R5 still off after one edge", 1'b0);
        step(1);
        check_en("R5 back after two edges", 1'b1);
        check("R1 fs unchanged", 32'(fs_latched), 32'b101);
        check("R3 sel unchanged", 32'(sel24), 1);
        check("R2 oe stays", 32'(pin_oe), 32'hF);

        // R6 directed stop
        pci_stop = 1'b1; #1;
        check_en("R6 stop gates pci only", 1'b1);
        pci_stop = 1'b0;

        // R7 same value write: no pulse
        ratio_wr = 1'b1; ratio_wr_data = 3'b101;
        step(1);
        ratio_wr = 1'b0;
        check("R7 same value no pulse", 32'(sys_rst_n), 1);

        // R7 differing write: pulse of RST cycles
        ratio_wr = 1'b1; ratio_wr_data = 3'b011;
        step(1);
        ratio_wr = 1'b0;
        check("R7 fs updated", 32'(fs_latched), 32'b011);
        for (int i = 0; i < RST; i++) begin
            check("R7 pulse low", 32'(sys_rst_n), 0);
            step(1);
        end
        check("R7 pulse ends", 32'(sys_rst_n), 1);

        // R8 watchdog with rearm
        wdt_arm = 1'b1;
        step(1);
        wdt_arm = 1'b0;
        step(WDT / 2);
        wdt_arm = 1'b1;
        step(1);
        wdt_arm = 1'b0;
        step(WDT - 1);
        check("R8 not yet expired after rearm", 32'(sys_rst_n), 1);
        step(1);
        check("R8 expiry pulse", 32'(sys_rst_n), 0);
        step(RST + 2 * WDT);
        check("R8 one-shot", 32'(sys_rst_n), 1);

        // Random: pci_stop and ratio writes against a model
        fs_model = fs_latched; rst_model = 0;
        for (int k = 0; k < 300; k++) begin
            pci_stop = 1'($urandom);
            ratio_wr = ($urandom % 4) == 0;
            ratio_wr_data = FS_W'($urandom);
            if (ratio_wr && ratio_wr_data != fs_model) begin
                fs_model = ratio_wr_data; rst_model = RST;
            end else if (rst_model > 0) begin
                rst_model--;
            end
            step(1);
            check_en("R6 random stop", 1'b1);
            check("R7 random fs", 32'(fs_latched), 32'(fs_model));
            check("R7 random rst", 32'(sys_rst_n), 32'(rst_model == 0));
        end
        ratio_wr = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule